// File: doc/BRIEF.md
# Cascadable 8-to-3 Priority Encoder

This combinational encoder looks at eight request lines and reports the index of the highest-numbered one that is set, together with a flag saying whether any request was found. An active-high enable gates the whole stage. While the enable is low, every output is held at zero, whatever the requests are.

A cascade output goes high only when the stage is enabled and none of its requests is set. Two stages can therefore be chained into a 16-to-4 encoder. The upper stage takes request lines 15..8 and its enable is the enable of the chain. Its cascade output drives the enable of the lower stage, which takes lines 7..0. The chain forms its result as follows:

- The top address bit is the upper stage's valid flag.
- The low three address bits are the OR of the two stage addresses.
- The chain's valid flag is the OR of the two valid flags.

For standalone use, tie the enable high.

Top module: `prio_enc_cascade`

## Requirements
- R1: valid_o is 1 exactly when en_i is 1 and at least one bit of req_i is 1.
- R2: While en_i is 0, addr_o, valid_o and eo_o are all 0 for every value of req_i.
- R3: eo_o is 1 exactly when en_i is 1 and req_i is all zeros.
- R4: With en_i high and a request present, addr_o is the index of the highest set bit of req_i. Bit 7 has the highest priority and bit 0 the lowest, so lower bits are ignored whenever a higher bit is set.
- R5: With en_i high and req_i all zeros, the outputs are addr_o = 0, valid_o = 0 and eo_o = 1.
- R6: When two stages are chained (upper eo_o to lower en_i), the 4-bit result is the index of the highest set bit among 16 requests. Its bit 3 is the upper valid_o and bits 2..0 are the OR of the two addr_o values. The chain's valid is the OR of both valid_o, and the chain's cascade output is the lower stage's eo_o.
- R7: The outputs depend only on the present inputs: a new req_i or en_i value appears at the outputs with no clock involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_i | input | N_IN (8) | Request lines; a higher index has higher priority |
| en_i | input | 1 | Active-high stage enable |
| addr_o | output | clog2(N_IN) (3) | Index of the highest active request, 0 when none or disabled |
| valid_o | output | 1 | High when enabled and at least one request is set |
| eo_o | output | 1 | Cascade enable for the next lower stage: enabled and no request set |

## Verification
The bound checker watches every input change. It checks that the disabled stage outputs only zeros and that the cascade output follows enable-and-idle. It also checks that a reported address always points at a set request with no higher request set, and that valid and cascade output are never high together. Only the bench scenarios can show the 16-to-4 chain. Those scenarios cover the hand-off between stages, upper requests masking the lower stage entirely, and the exact addresses for walking-one, all-ones and pseudo-random patterns against an independent reference.

// File: rtl/pe_pkg.sv
package pe_pkg;
  parameter int unsigned PE_N_DEF = 8;

  function automatic int unsigned pe_idx_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/pe_scan.sv
module pe_scan #(
  parameter int unsigned N     = pe_pkg::PE_N_DEF,
  parameter int unsigned IDX_W = pe_pkg::pe_idx_w(N)
) (
  input  logic [N-1:0]     req_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  // ascending sweep: the last hit is the highest index
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i]) begin
        idx_o = IDX_W'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pe_gate.sv
module pe_gate #(
  parameter int unsigned IDX_W = 3
) (
  input  logic             en_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             any_i,
  output logic [IDX_W-1:0] addr_o,
  output logic             valid_o,
  output logic             eo_o
);
  always_comb begin
    addr_o  = en_i ? idx_i : '0;
    valid_o = en_i & any_i;
    eo_o    = en_i & ~any_i;
  end
endmodule

// File: rtl/prio_enc_cascade.sv
module prio_enc_cascade #(
  parameter int unsigned N_IN = pe_pkg::PE_N_DEF,
  localparam int unsigned AW  = pe_pkg::pe_idx_w(N_IN)
) (
  input  logic [N_IN-1:0] req_i,
  input  logic            en_i,
  output logic [AW-1:0]   addr_o,
  output logic            valid_o,
  output logic            eo_o
);
  logic [AW-1:0] scan_idx;
  logic          scan_any;

  pe_scan #(.N(N_IN), .IDX_W(AW)) i_scan (
    .req_i (req_i),
    .idx_o (scan_idx),
    .any_o (scan_any)
  );

  pe_gate #(.IDX_W(AW)) i_gate (
    .en_i    (en_i),
    .idx_i   (scan_idx),
    .any_i   (scan_any),
    .addr_o  (addr_o),
    .valid_o (valid_o),
    .eo_o    (eo_o)
  );
endmodule

// File: rtl/pe_chk.sv
module pe_chk #(
  parameter int unsigned N_IN = 8,
  parameter int unsigned AW   = 3
) (
  input logic [N_IN-1:0] req_i,
  input logic            en_i,
  input logic [AW-1:0]   addr_o,
  input logic            valid_o,
  input logic            eo_o
);
  always_comb begin
    if (!$isunknown({req_i, en_i, addr_o, valid_o, eo_o})) begin
      assert_off_zero_R2: assert (en_i || (addr_o == '0 && !valid_o && !eo_o))
        else $error("R2: disabled stage drives nonzero output");
      assert_eo_idle_R3: assert (eo_o == (en_i && req_i == '0))
        else $error("R3: cascade output mismatch");
      assert_valid_any_R1: assert (valid_o == (en_i && req_i != '0))
        else $error("R1: valid mismatch");
      assert_addr_hit_R4: assert (!valid_o || req_i[addr_o])
        else $error("R4: address points at idle request");
      assert_addr_top_R4: assert (!valid_o || ((req_i >> addr_o) >> 1) == '0)
        else $error("R4: higher request skipped");
      assert_idle_addr_R5: assert (valid_o || addr_o == '0)
        else $error("R5: idle address nonzero");
      assert_excl_R3: assert ($onehot0({valid_o, eo_o}))
        else $error("R3: valid and eo both high");
    end
  end
endmodule

bind prio_enc_cascade pe_chk #(.N_IN(N_IN), .AW(AW)) i_pe_chk (
  .req_i   (req_i),
  .en_i    (en_i),
  .addr_o  (addr_o),
  .valid_o (valid_o),
  .eo_o    (eo_o)
);

// File: tb/test_prio_enc_cascade.sv
module pe_chain16 (
  input  logic [15:0] req_i,
  input  logic        en_i,
  output logic [3:0]  addr_o,
  output logic        valid_o,
  output logic        eo_o
);
  logic [2:0] hi_addr, lo_addr;
  logic       hi_valid, lo_valid, hi_eo;

  prio_enc_cascade i_hi (.req_i(req_i[15:8]), .en_i(en_i),  .addr_o(hi_addr),
                         .valid_o(hi_valid), .eo_o(hi_eo));
  prio_enc_cascade i_lo (.req_i(req_i[7:0]),  .en_i(hi_eo), .addr_o(lo_addr),
                         .valid_o(lo_valid), .eo_o(eo_o));

  assign addr_o  = {hi_valid, hi_addr | lo_addr};
  assign valid_o = hi_valid | lo_valid;
endmodule

module test_prio_enc_cascade;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [2:0] addr;
    logic       valid;
    logic       eo;
    logic [3:0] c_addr;
    logic       c_valid;
    logic       c_eo;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  req = '0;
  logic        en = 1'b0;
  logic [15:0] creq = '0;
  logic        cen = 1'b0;
  logic [2:0]  addr;
  logic        valid, eo;
  logic [3:0]  c_addr;
  logic        c_valid, c_eo;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;
  exp_t        q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_enc_cascade i_prio_enc_cascade (
    .req_i(req), .en_i(en), .addr_o(addr), .valid_o(valid), .eo_o(eo)
  );
  pe_chain16 i_chain (
    .req_i(creq), .en_i(cen), .addr_o(c_addr), .valid_o(c_valid), .eo_o(c_eo)
  );

  // reference: scan downward from the top bit
  function automatic exp_t ref_model(logic [7:0] r, logic e, logic [15:0] cr, logic ce, string tag);
    exp_t x;
    x.addr = '0; x.valid = 1'b0; x.eo = e && (r == '0);
    if (e) for (int i = 7; i >= 0; i--) if (r[i] && !x.valid) begin x.addr = 3'(i); x.valid = 1'b1; end
    x.c_addr = '0; x.c_valid = 1'b0; x.c_eo = ce && (cr == '0);
    if (ce) for (int i = 15; i >= 0; i--) if (cr[i] && !x.c_valid) begin x.c_addr = 4'(i); x.c_valid = 1'b1; end
    x.tag = tag;
    return x;
  endfunction

  task automatic drive(logic [7:0] r, logic e, logic [15:0] cr, logic ce, string tag);
    @(posedge clk);
    req = r; en = e; creq = cr; cen = ce;
    q.push_back(ref_model(r, e, cr, ce, tag));
  endtask

  task automatic cmp(string tag, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // monitor: sample between edges, after inputs have settled (R7)
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t x;
        x = q.pop_front();
        cmp(x.tag, "addr", int'(addr), int'(x.addr));
        cmp(x.tag, "valid", int'(valid), int'(x.valid));
        cmp(x.tag, "eo", int'(eo), int'(x.eo));
        cmp(x.tag, "chain_addr", int'(c_addr), int'(x.c_addr));
        cmp(x.tag, "chain_valid", int'(c_valid), int'(x.c_valid));
        cmp(x.tag, "chain_eo", int'(c_eo), int'(x.c_eo));
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset state: disabled, idle
    drive(8'h00, 1'b0, 16'h0000, 1'b0, "R2_reset");
    // R2: disabled ignores requests
    drive(8'hFF, 1'b0, 16'hFFFF, 1'b0, "R2_all");
    drive(8'h81, 1'b0, 16'h0100, 1'b0, "R2_mix");
    // R5 / R3: enabled idle
    drive(8'h00, 1'b1, 16'h0000, 1'b1, "R5_idle");
    // R4 / R1: walking one
    for (int i = 0; i < 8; i++) drive(8'(1 << i), 1'b1, 16'(1 << i), 1'b1, "R4_walk");
    // R4: lower bits ignored under a higher one
    drive(8'hFF, 1'b1, 16'hFFFF, 1'b1, "R4_all");
    drive(8'h0F, 1'b1, 16'h00FF, 1'b1, "R4_low");
    drive(8'h90, 1'b1, 16'h8001, 1'b1, "R4_ends");
    // R6: chain hand-off and masking
    for (int i = 8; i < 16; i++) drive(8'h01, 1'b1, 16'(1 << i), 1'b1, "R6_upper");
    drive(8'h02, 1'b1, 16'h0180, 1'b1, "R6_mask");
    drive(8'h02, 1'b1, 16'h0007, 1'b1, "R6_lower");
    drive(8'h00, 1'b1, 16'h0000, 1'b0, "R6_off");
    // R1 / R3 / R6 / R7: pseudo-random patterns
    lfsr = 16'hACE1;
    for (int i = 0; i < 64; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive(lfsr[7:0] & lfsr[15:8], lfsr[3] | lfsr[9], lfsr & {lfsr[7:0], lfsr[15:8]}, lfsr[5] | lfsr[2], "R1_rand");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule